// File: doc/BRIEF.md
# NAND Page Read Sequencer

This block carries out a single unbuffered page read from a large-page NAND flash device. A one-cycle start request supplies a chip number and a 24-bit row (page) address. The block enables the chosen chip, waits for the device to report ready, and issues the read setup command 0x00. It then sends two zero column bytes, the three row bytes with the low byte first, and the confirm command 0x30. The device then moves the page from its array into its internal register. The block waits for ready a second time, reads the page and spare area one byte per cycle, hands each byte out on a byte/valid pair, and releases the chip.

Each ready wait gives up after a fixed number of polls. When that happens the block raises a one-cycle timeout flag and carries on, so a stuck ready line can never hang the sequence. The number of bytes read, the number of chips, the poll limit and the pause between the confirm command and the second ready wait are all parameters. The defaults read 4314 bytes (4096 data plus 218 spare) and poll 8192 times.

Top module: `nand_page_rd_seq`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `tmo_o`, `rd_valid_o` and all strobes are low, and every bit of `nand_ce_o` is low.
- R2: A start request accepted while idle captures the chip number and row address and raises `busy_o` on the next cycle. From then until the deselect cycle, `nand_ce_o` is one-hot: bit `chip` is set and no other bit is.
- R3: A start request that arrives while `busy_o` is high is ignored. The running read keeps its chip and address, and no second read follows it.
- R4: No command or address strobe is issued until `nand_rdy_i` has been sampled high in the first ready wait.
- R5: The bus sequence is seven write strobes (`nand_we_o` high for one cycle each), in this order: 0x00 with `nand_cle_o`; 0x00 and 0x00 with `nand_ale_o`; row bits 7:0, 15:8 and 23:16 with `nand_ale_o`; then 0x30 with `nand_cle_o`. `nand_cle_o` and `nand_ale_o` are never high together.
- R6: After the confirm strobe the block waits `SETTLE_CYC` cycles, then polls `nand_rdy_i`. No read strobe is issued until ready has been sampled high.
- R7: Exactly `PAGE_BYTES` read strobes (`nand_re_o`) are issued. The byte on `nand_dq_i` at each strobe appears on `rd_data_o` with `rd_valid_o` high in the following cycle, in the order read.
- R8: If `nand_rdy_i` stays low for `TIMEOUT_POLLS` consecutive polls in either wait, `tmo_o` pulses for exactly one cycle and the sequence continues as though ready had been seen.
- R9: After the last read strobe, `nand_ce_o` goes all low and `done_o` pulses for one cycle, together with the last `rd_valid_o`. `busy_o` is low on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, one cycle |
| chip_i | input | CHIP_W | Chip number for the read |
| row_i | input | 24 | Page (row) address |
| busy_o | output | 1 | High while a read is in progress |
| done_o | output | 1 | One-cycle pulse at deselect |
| tmo_o | output | 1 | One-cycle pulse when a ready wait gives up |
| nand_ce_o | output | NUM_CHIPS | One-hot chip enable, active high |
| nand_cle_o | output | 1 | Command latch enable |
| nand_ale_o | output | 1 | Address latch enable |
| nand_we_o | output | 1 | Write strobe for command and address bytes |
| nand_re_o | output | 1 | Read strobe for data bytes |
| nand_dq_o | output | 8 | Command or address byte |
| nand_dq_i | input | 8 | Data byte from the device |
| nand_rdy_i | input | 1 | Device ready (high) or busy (low) |
| rd_data_o | output | 8 | Byte read from the page |
| rd_valid_o | output | 1 | `rd_data_o` is valid |

## Verification
The bench models the device. The ready line drops for several cycles after the confirm command, and every read returns a known byte pattern. The bench holds ready low at the start, so a design that skips the first wait would put its setup command on the bus too early. Mixing up the row byte order would show up as mismatched address bytes. Another start request is injected mid-read: a design that accepts it would switch chip enables or run a second sequence. Ready is stuck low in each wait in turn. A design without the poll limit would hang, and one that counts polls wrongly would move on at the wrong cycle or pulse `tmo_o` more than once.

// File: rtl/nprd_pkg.sv
package nprd_pkg;
   localparam int unsigned ROW_W = 24;
   localparam int unsigned ROW_BYTES = ROW_W / 8;
   localparam logic [7:0] OP_SETUP = 8'h00;
   localparam logic [7:0] OP_CONFIRM = 8'h30;
   localparam logic [7:0] COL_ZERO = 8'h00;

   typedef enum logic [3:0] {
      S_IDLE, S_SEL, S_WAIT_A, S_CMD_SETUP, S_COL0, S_COL1,
      S_ROW0, S_ROW1, S_ROW2, S_CMD_GO, S_SETTLE, S_WAIT_B,
      S_XFER, S_DESEL
   } seq_state_t;
endpackage

// File: rtl/nprd_rdy_wait.sv
module nprd_rdy_wait #(
   parameter int unsigned LIMIT = 8192
) (
   input  logic clk,
   input  logic rst_n,
   input  logic active_i,
   input  logic rdy_i,
   output logic go_o,
   output logic tmo_o
);
   localparam int unsigned CW = $clog2(LIMIT + 1);
   logic [CW-1:0] polls;
   logic at_lim;

   assign at_lim = (polls == CW'(LIMIT - 1));
   assign go_o   = active_i && (rdy_i || at_lim);
   assign tmo_o  = active_i && !rdy_i && at_lim;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  polls <= '0;
      else if (!active_i || go_o)  polls <= '0;
      else                         polls <= polls + 1'b1;
   end
endmodule

// File: rtl/nprd_addr_byte.sv
module nprd_addr_byte
   import nprd_pkg::*;
(
   input  seq_state_t        st_i,
   input  logic [ROW_W-1:0]  row_i,
   output logic [7:0]        byte_o
);
   logic [7:0] row_b [ROW_BYTES];

   for (genvar g = 0; g < ROW_BYTES; g++) begin : g_split
      assign row_b[g] = row_i[8*g +: 8];
   end

   always_comb begin
      unique case (st_i)
         S_CMD_SETUP:    byte_o = OP_SETUP;
         S_COL0, S_COL1: byte_o = COL_ZERO;
         S_ROW0:         byte_o = row_b[0];
         S_ROW1:         byte_o = row_b[1];
         S_ROW2:         byte_o = row_b[2];
         S_CMD_GO:       byte_o = OP_CONFIRM;
         default:        byte_o = 8'h00;
      endcase
   end
endmodule

// File: rtl/nprd_xfer_ctr.sv
module nprd_xfer_ctr #(
   parameter int unsigned COUNT = 4314
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   output logic last_o
);
   localparam int unsigned CW = $clog2(COUNT + 1);
   logic [CW-1:0] cnt;

   assign last_o = run_i && (cnt == CW'(COUNT - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt <= '0;
      else if (!run_i)  cnt <= '0;
      else              cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/nand_page_rd_seq.sv
module nand_page_rd_seq
   import nprd_pkg::*;
#(
   parameter int unsigned NUM_CHIPS     = 4,
   parameter int unsigned PAGE_BYTES    = 4314,
   parameter int unsigned TIMEOUT_POLLS = 8192,
   parameter int unsigned SETTLE_CYC    = 2,
   localparam int unsigned CHIP_W = (NUM_CHIPS > 1) ? $clog2(NUM_CHIPS) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start_i,
   input  logic [CHIP_W-1:0]    chip_i,
   input  logic [23:0]          row_i,
   output logic                 busy_o,
   output logic                 done_o,
   output logic                 tmo_o,
   output logic [NUM_CHIPS-1:0] nand_ce_o,
   output logic                 nand_cle_o,
   output logic                 nand_ale_o,
   output logic                 nand_we_o,
   output logic                 nand_re_o,
   output logic [7:0]           nand_dq_o,
   input  logic [7:0]           nand_dq_i,
   input  logic                 nand_rdy_i,
   output logic [7:0]           rd_data_o,
   output logic                 rd_valid_o
);
   localparam int unsigned SW = $clog2(SETTLE_CYC + 1);

   if (NUM_CHIPS < 1)     begin : g_bad_chips   $error("NUM_CHIPS must be at least 1");     end
   if (PAGE_BYTES < 1)    begin : g_bad_page    $error("PAGE_BYTES must be at least 1");    end
   if (TIMEOUT_POLLS < 1) begin : g_bad_timeout $error("TIMEOUT_POLLS must be at least 1"); end
   if (SETTLE_CYC < 1)    begin : g_bad_settle  $error("SETTLE_CYC must be at least 1");    end

   seq_state_t st, st_nx;
   logic [CHIP_W-1:0] chip_q;
   logic [ROW_W-1:0]  row_q;
   logic [SW-1:0]     settle_q;
   logic [NUM_CHIPS-1:0] sel_dec;
   logic wait_go, wait_tmo, xfer_last, settle_end, in_wait, ce_on;

   assign in_wait    = (st == S_WAIT_A) || (st == S_WAIT_B);
   assign settle_end = (settle_q == SW'(SETTLE_CYC - 1));

   nprd_rdy_wait #(.LIMIT(TIMEOUT_POLLS)) u_wait (
      .clk(clk), .rst_n(rst_n), .active_i(in_wait), .rdy_i(nand_rdy_i),
      .go_o(wait_go), .tmo_o(wait_tmo)
   );

   nprd_xfer_ctr #(.COUNT(PAGE_BYTES)) u_xfer (
      .clk(clk), .rst_n(rst_n), .run_i(st == S_XFER), .last_o(xfer_last)
   );

   nprd_addr_byte u_addr (
      .st_i(st), .row_i(row_q), .byte_o(nand_dq_o)
   );

   for (genvar g = 0; g < NUM_CHIPS; g++) begin : g_dec
      assign sel_dec[g] = (chip_q == CHIP_W'(g));
   end

   always_comb begin
      st_nx = st;
      unique case (st)
         S_IDLE:      if (start_i) st_nx = S_SEL;
         S_SEL:       st_nx = S_WAIT_A;
         S_WAIT_A:    if (wait_go) st_nx = S_CMD_SETUP;
         S_CMD_SETUP: st_nx = S_COL0;
         S_COL0:      st_nx = S_COL1;
         S_COL1:      st_nx = S_ROW0;
         S_ROW0:      st_nx = S_ROW1;
         S_ROW1:      st_nx = S_ROW2;
         S_ROW2:      st_nx = S_CMD_GO;
         S_CMD_GO:    st_nx = S_SETTLE;
         S_SETTLE:    if (settle_end) st_nx = S_WAIT_B;
         S_WAIT_B:    if (wait_go) st_nx = S_XFER;
         S_XFER:      if (xfer_last) st_nx = S_DESEL;
         S_DESEL:     st_nx = S_IDLE;
         default:     st_nx = S_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st         <= S_IDLE;
         chip_q     <= '0;
         row_q      <= '0;
         settle_q   <= '0;
         tmo_o      <= 1'b0;
         rd_valid_o <= 1'b0;
         rd_data_o  <= 8'h00;
      end else begin
         st         <= st_nx;
         tmo_o      <= wait_tmo;
         rd_valid_o <= (st == S_XFER);
         if (st == S_XFER) rd_data_o <= nand_dq_i;
         if (st == S_IDLE && start_i) begin
            chip_q <= chip_i;
            row_q  <= row_i;
         end
         if (st == S_SETTLE) settle_q <= settle_q + 1'b1;
         else                settle_q <= '0;
      end
   end

   assign ce_on      = (st != S_IDLE) && (st != S_DESEL);
   assign nand_ce_o  = ce_on ? sel_dec : '0;
   assign nand_cle_o = (st == S_CMD_SETUP) || (st == S_CMD_GO);
   assign nand_ale_o = (st == S_COL0) || (st == S_COL1) || (st == S_ROW0) ||
                       (st == S_ROW1) || (st == S_ROW2);
   assign nand_we_o  = nand_cle_o || nand_ale_o;
   assign nand_re_o  = (st == S_XFER);
   assign busy_o     = (st != S_IDLE);
   assign done_o     = (st == S_DESEL);
endmodule

// File: rtl/nprd_checker.sv
module nprd_checker #(
   parameter int unsigned NUM_CHIPS = 4
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 busy,
   input logic                 done,
   input logic                 tmo,
   input logic [NUM_CHIPS-1:0] ce,
   input logic                 cle,
   input logic                 ale,
   input logic                 we,
   input logic                 re,
   input logic                 rd_valid
);
   assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (ce == '0 && !we && !re));
   assert_ce_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(ce));
   assert_ce_needs_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (|ce) |-> busy);
   assert_latch_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !(cle && ale));
   assert_strobe_selected_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (we || re) |-> (|ce));
   assert_valid_after_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> $past(re));
   assert_tmo_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
      tmo |=> !tmo);
   assert_done_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !busy);
endmodule

bind nand_page_rd_seq nprd_checker #(.NUM_CHIPS(NUM_CHIPS)) u_chk (
   .clk(clk), .rst_n(rst_n), .busy(busy_o), .done(done_o), .tmo(tmo_o),
   .ce(nand_ce_o), .cle(nand_cle_o), .ale(nand_ale_o), .we(nand_we_o),
   .re(nand_re_o), .rd_valid(rd_valid_o)
);

// File: tb/nand_page_rd_seq_tb.sv
module nand_page_rd_seq_tb;
   localparam int NCH = 4, PG = 20, TMO = 16, STL = 2, CW = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic start_i = 1'b0;
   logic [CW-1:0] chip_i = '0;
   logic [23:0] row_i = '0;
   logic busy_o, done_o, tmo_o, cle, ale, we, re, rd_valid_o, nand_rdy;
   logic [NCH-1:0] ce;
   logic [7:0] dq_o, dq_i, rd_data_o;

   nand_page_rd_seq #(.NUM_CHIPS(NCH), .PAGE_BYTES(PG), .TIMEOUT_POLLS(TMO),
                      .SETTLE_CYC(STL)) u_dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .chip_i(chip_i), .row_i(row_i),
      .busy_o(busy_o), .done_o(done_o), .tmo_o(tmo_o), .nand_ce_o(ce),
      .nand_cle_o(cle), .nand_ale_o(ale), .nand_we_o(we), .nand_re_o(re),
      .nand_dq_o(dq_o), .nand_dq_i(dq_i), .nand_rdy_i(nand_rdy),
      .rd_data_o(rd_data_o), .rd_valid_o(rd_valid_o));

   // stimulus-owned state
   int t_tests = 0, t_fail = 0;
   logic hold_low = 1'b0, long_busy = 1'b0, skip_rdy_a = 1'b0;
   int cur_chip = 0, seed = 0;
   logic [7:0] exp_dq [7];
   logic       exp_cle [7];

   // device model
   int rd_idx = 0, dev_busy = 0;
   logic rdy_at_edge = 1'b0;
   assign nand_rdy = !hold_low && (dev_busy == 0);
   function automatic logic [7:0] pat(int i, int s);
      return 8'(i * 37 + s);
   endfunction
   assign dq_i = pat(rd_idx, seed);

   always @(posedge clk) begin
      rdy_at_edge <= nand_rdy;
      if (start_i && !busy_o) rd_idx <= 0;
      else if (re) rd_idx <= rd_idx + 1;
      if (we && cle && dq_o == 8'h30) dev_busy <= long_busy ? 40 : 5;
      else if (dev_busy > 0) dev_busy <= dev_busy - 1;
   end

   // per-clock monitor
   int m_tests = 0, m_fail = 0;
   int ev = 0, dcnt = 0, tmo_seen = 0, op_cyc = 0, first_we_cyc = 0, first_re_rdy = 1;
   always @(negedge clk) begin
      if (rst_n) begin
         if (start_i && !busy_o) begin
            ev = 0; dcnt = 0; tmo_seen = 0; op_cyc = 0; first_re_rdy = 1;
         end else begin
            op_cyc++;
         end
         m_tests++;
         if (ce !== ((busy_o && !done_o) ? NCH'(1 << cur_chip) : NCH'(0))) begin
            m_fail++;
            $display("FAIL R2 chip enable: got %b exp chip %0d busy %b", ce, cur_chip, busy_o);
         end
         if (we) begin
            m_tests++;
            if (ev > 6) begin
               m_fail++; $display("FAIL R5 extra write strobe: got %0d strobes exp 7", ev + 1);
            end else if (cle !== exp_cle[ev] || ale !== !exp_cle[ev] || dq_o !== exp_dq[ev]) begin
               m_fail++;
               $display("FAIL R5 strobe %0d: got cle%b ale%b %h exp cle%b %h",
                        ev, cle, ale, dq_o, exp_cle[ev], exp_dq[ev]);
            end
            if (ev == 0) begin
               first_we_cyc = op_cyc;
               if (!skip_rdy_a && !rdy_at_edge) begin
                  m_fail++; $display("FAIL R4 setup command issued while busy: got rdy 0 exp 1");
               end
            end
            ev++;
         end
         if (re && dcnt == 0 && !long_busy && !rdy_at_edge) first_re_rdy = 0;
         if (rd_valid_o) begin
            m_tests++;
            if (rd_data_o !== pat(dcnt, seed)) begin
               m_fail++;
               $display("FAIL R7 byte %0d: got %h exp %h", dcnt, rd_data_o, pat(dcnt, seed));
            end
            dcnt++;
         end
         if (tmo_o) tmo_seen++;
      end
   end

   task automatic chk(bit ok, string req, int got, int expv);
      t_tests++;
      if (!ok) begin
         t_fail++;
         $display("FAIL %s: got %0d exp %0d", req, got, expv);
      end
   endtask

   task automatic run_op(int chip, logic [23:0] row, int s, int low_a, bit lb,
                         int exp_tmo, bit inj);
      int waited;
      cur_chip = chip; seed = s; long_busy = lb; skip_rdy_a = (low_a < 0);
      exp_dq[0] = 8'h00; exp_dq[1] = 8'h00; exp_dq[2] = 8'h00;
      exp_dq[3] = row[7:0]; exp_dq[4] = row[15:8]; exp_dq[5] = row[23:16];
      exp_dq[6] = 8'h30;
      for (int k = 0; k < 7; k++) exp_cle[k] = (k == 0 || k == 6);
      @(posedge clk); #1;
      start_i = 1'b1; chip_i = CW'(chip); row_i = row; hold_low = (low_a != 0);
      @(posedge clk); #1;
      start_i = 1'b0;
      chk(busy_o === 1'b1, "R2 busy after start", int'(busy_o), 1);
      if (inj) begin
         repeat (2) @(posedge clk);
         #1; start_i = 1'b1; chip_i = CW'(chip ^ 1); row_i = ~row;
         @(posedge clk); #1; start_i = 1'b0;
      end
      if (low_a > 0) begin
         repeat (low_a) @(posedge clk);
         #1; hold_low = 1'b0;
      end else if (low_a < 0) begin
         while (!we) @(negedge clk);
         #1; hold_low = 1'b0;
      end
      waited = 0;
      do begin @(negedge clk); waited++; end while (!done_o && waited < 2000);
      #1;
      chk(ev == 7, "R5 strobe count", ev, 7);
      chk(dcnt == PG, "R7 byte count", dcnt, PG);
      chk(tmo_seen == exp_tmo, "R8 timeout pulses", tmo_seen, exp_tmo);
      chk(first_re_rdy == 1, "R6 read before ready", first_re_rdy, 1);
      chk(ce == '0, "R9 deselect at done", int'(ce), 0);
      if (low_a > 0) chk(first_we_cyc >= low_a, "R4 setup wait", first_we_cyc, low_a);
      if (low_a < 0) chk(first_we_cyc == TMO + 2, "R8 first timeout cycle", first_we_cyc, TMO + 2);
      @(negedge clk);
      chk(busy_o === 1'b0, "R9 busy released", int'(busy_o), 0);
      repeat (3) @(negedge clk);
      chk(busy_o === 1'b0 && ce == '0, "R3 no restart after ignored start",
          int'(busy_o), 0);
   endtask

   logic wd_fired = 1'b0;
   initial begin
      #(5.0 * 150000);
      wd_fired = 1'b1;
      $display("FAIL watchdog: got hung run exp completion");
      $display("  [TB] %0d tests run, %0d failed", t_tests + m_tests + 1, t_fail + m_fail + 1);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(busy_o === 0 && done_o === 0 && tmo_o === 0 && rd_valid_o === 0 &&
          we === 0 && re === 0 && cle === 0 && ale === 0, "R1 reset outputs", int'(busy_o), 0);
      chk(ce == '0, "R1 reset chip enables", int'(ce), 0);
      rst_n = 1'b1;
      run_op(0, 24'h123456, 3, 0, 1'b0, 0, 1'b0);
      run_op(3, 24'hA5C30F, 91, 10, 1'b0, 0, 1'b1);
      run_op(2, 24'hFFFFFF, 200, -1, 1'b0, 1, 1'b0);
      run_op(1, 24'h00FF01, 17, 0, 1'b1, 1, 1'b0);
      run_op(0, 24'h800001, 5, 0, 1'b0, 0, 1'b0);
      if (!wd_fired) begin
         $display("  [TB] %0d tests run, %0d failed", t_tests + m_tests, t_fail + m_fail);
         $finish;
      end
   end
endmodule